// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the 15-bit instruction fetch address for a small 8-bit controller. Its program space is 32 pages of 1024 words. Each instruction cycle is marked by `step_i`. In that cycle the block takes a decoded control code and moves the counter on. The next address is built from the jump target, the accumulator and the page-select value. Each kind of write treats the page bits and address bits 9..8 in its own way.

A 32-entry circular return stack holds the return addresses for calls and interrupts. An interrupt pulse takes priority over the instruction decoded in that cycle. It sends the counter to word 8 of page 0 and captures accumulator, status and page-select into a saved context. A return-from-interrupt signals the rest of the core to restore that context and pops the return address.

Top module: `paged_pc`

## Requirements
- R1: While `rst_ni` is low, `pc_o` and all three saved-context outputs are zero and the stack is cleared. A pop as the first stack operation after reset yields address 0.
- R2: In a cycle with `step_i` low, nothing changes. With `step_i` high, no interrupt and `op_i`=0 (none), `pc_o` increments by one and wraps from 0x7FFF to 0x0000.
- R3: `op_i`=1 (jump) loads `pc_o` with {`page_i`, `target_i`}.
- R4: `op_i`=2 (call) loads `pc_o` as a jump does and pushes the old `pc_o`+1 onto the stack.
- R5: `op_i`=3 (return, also used for return-with-literal) and `op_i`=4 (return-from-interrupt) load `pc_o` with the most recently pushed address that has not yet been popped, and remove it.
- R6: `op_i`=5 (register write to PC) loads `pc_o` with {`page_i`, 2'b00, `acc_i`}.
- R7: `op_i`=6 (add to PC) computes s = `pc_o` + `acc_i` and loads {`page_i`, 2'b00, s[7:0]}.
- R8: `op_i`=7 (table read) loads `pc_o` + `acc_i` modulo 2^15. `page_i` is ignored, and bits 9..8 keep the carry result.
- R9: `irq_i` high with `step_i` high overrides `op_i`. It pushes the current `pc_o`, loads `pc_o` with 0x0008, and captures `acc_i`, `status_i` and `page_i` into `acc_sv_o`, `stat_sv_o` and `page_sv_o`. Those outputs change in no other cycle.
- R10: `restore_o` is high, combinationally, exactly in a cycle with `step_i` high, `irq_i` low and `op_i`=4.
- R11: The stack pointer is a 5-bit circular pointer. A 33rd unpopped push overwrites the oldest entry, and a pop past the oldest entry wraps to the slot pushed last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Instruction cycle enable |
| op_i | input | 3 | Decoded PC operation code |
| target_i | input | 10 | Jump or call target offset |
| acc_i | input | 8 | Accumulator value |
| status_i | input | 8 | Status register value |
| page_i | input | 5 | Page-select value |
| irq_i | input | 1 | Qualified interrupt request pulse |
| pc_o | output | 15 | Fetch address |
| acc_sv_o | output | 8 | Saved accumulator |
| stat_sv_o | output | 8 | Saved status |
| page_sv_o | output | 5 | Saved page-select |
| restore_o | output | 1 | Restore saved context this cycle |

## Verification
The bench goes after the counter wrap at 0x7FFF. A design that carried into a 16th bit or saturated would fetch the wrong word there. It runs 33 calls followed by 34 returns, so an overwrite or wrap error in the stack pointer shows up as a wrong return address. It pops an empty stack right after reset, where a design that reads the wrong slot returns a stale address. Random mixes of add-to-PC and table-read with carries into bit 8 catch a design that clears or keeps bits 9..8 in the wrong case. Interrupts that land on a call or return check that the decoded operation is dropped and that the context is captured only then.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_JMP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_RETI  = 3'd4,
    OP_MOVPC = 3'd5,
    OP_ADDPC = 3'd6,
    OP_TBL   = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pc_next.sv
module pc_next
  import pc_pkg::*;
#(
  parameter int PAGE_W = 5,
  parameter int OFS_W  = 10,
  parameter int ACC_W  = 8,
  localparam int PC_W  = PAGE_W + OFS_W
) (
  input  pc_op_e            op_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   top_i,
  input  logic [OFS_W-1:0]  target_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PC_W-1:0]   pc_nx_o,
  output logic [PC_W-1:0]   pc_inc_o
);
  logic [PC_W-1:0] sum;

  assign pc_inc_o = pc_i + 1'b1;
  assign sum      = pc_i + PC_W'(acc_i);

  always_comb begin
    unique case (op_i)
      OP_JMP, OP_CALL: pc_nx_o = {page_i, target_i};
      OP_RET, OP_RETI: pc_nx_o = top_i;
      OP_MOVPC:        pc_nx_o = {page_i, {(OFS_W-ACC_W){1'b0}}, acc_i};
      OP_ADDPC:        pc_nx_o = {page_i, {(OFS_W-ACC_W){1'b0}}, sum[ACC_W-1:0]};
      OP_TBL:          pc_nx_o = sum;
      default:         pc_nx_o = pc_inc_o;
    endcase
  end
endmodule

// File: rtl/pc_stack.sv
module pc_stack #(
  parameter int DEPTH = 32,
  parameter int W     = 15,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o
);
  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp_q;

  // sp_q points at the next free slot; wraps silently in both directions
  assign top_o = mem[sp_q - 1'b1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_i) begin
      mem[sp_q] <= data_i;
      sp_q      <= sp_q + 1'b1;
    end else if (pop_i) begin
      sp_q <= sp_q - 1'b1;
    end
  end
endmodule

// File: rtl/pc_ctx.sv
module pc_ctx #(
  parameter int ACC_W  = 8,
  parameter int STAT_W = 8,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [ACC_W-1:0]  acc_q_o,
  output logic [STAT_W-1:0] stat_q_o,
  output logic [PAGE_W-1:0] page_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q_o  <= '0;
      stat_q_o <= '0;
      page_q_o <= '0;
    end else if (save_i) begin
      acc_q_o  <= acc_i;
      stat_q_o <= status_i;
      page_q_o <= page_i;
    end
  end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
  import pc_pkg::*;
#(
  parameter int PAGE_W  = 5,
  parameter int OFS_W   = 10,
  parameter int ACC_W   = 8,
  parameter int STAT_W  = 8,
  parameter int DEPTH   = 32,
  parameter int IRQ_VEC = 8,
  localparam int PC_W   = PAGE_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [2:0]        op_i,
  input  logic [OFS_W-1:0]  target_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              irq_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [ACC_W-1:0]  acc_sv_o,
  output logic [STAT_W-1:0] stat_sv_o,
  output logic [PAGE_W-1:0] page_sv_o,
  output logic              restore_o
);
  pc_op_e          op;
  logic            take_irq, do_push, do_pop;
  logic [PC_W-1:0] pc_q, pc_nx, pc_inc, top;

  assign op       = pc_op_e'(op_i);
  assign take_irq = step_i & irq_i;
  // interrupt replaces the decoded operation of this cycle
  assign do_push  = take_irq | (step_i & (op == OP_CALL));
  assign do_pop   = step_i & ~irq_i & ((op == OP_RET) | (op == OP_RETI));
  assign restore_o = do_pop & (op == OP_RETI);

  pc_next #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .ACC_W(ACC_W)) u_next (
    .op_i     (op),
    .pc_i     (pc_q),
    .top_i    (top),
    .target_i (target_i),
    .acc_i    (acc_i),
    .page_i   (page_i),
    .pc_nx_o  (pc_nx),
    .pc_inc_o (pc_inc)
  );

  pc_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (do_push),
    .pop_i  (do_pop),
    .data_i (take_irq ? pc_q : pc_inc),
    .top_o  (top)
  );

  pc_ctx #(.ACC_W(ACC_W), .STAT_W(STAT_W), .PAGE_W(PAGE_W)) u_ctx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .save_i   (take_irq),
    .acc_i    (acc_i),
    .status_i (status_i),
    .page_i   (page_i),
    .acc_q_o  (acc_sv_o),
    .stat_q_o (stat_sv_o),
    .page_q_o (page_sv_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= '0;
    else if (take_irq) pc_q <= PC_W'(IRQ_VEC);
    else if (step_i)   pc_q <= pc_nx;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/paged_pc_chk.sv
module paged_pc_chk #(
  parameter int PAGE_W  = 5,
  parameter int OFS_W   = 10,
  parameter int ACC_W   = 8,
  parameter int STAT_W  = 8,
  parameter int IRQ_VEC = 8,
  localparam int PC_W   = PAGE_W + OFS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_i,
  input logic [2:0]        op_i,
  input logic [OFS_W-1:0]  target_i,
  input logic [ACC_W-1:0]  acc_i,
  input logic [STAT_W-1:0] status_i,
  input logic [PAGE_W-1:0] page_i,
  input logic              irq_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [ACC_W-1:0]  acc_sv_o,
  input logic [STAT_W-1:0] stat_sv_o,
  input logic [PAGE_W-1:0] page_sv_o,
  input logic              restore_o
);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o));

  a_r2_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !irq_i && op_i == 3'd0) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  a_r3_jmp_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !irq_i && op_i == 3'd1) |=> pc_o == {$past(page_i), $past(target_i)});

  a_r6_movpc_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !irq_i && op_i == 3'd5) |=>
      (pc_o[OFS_W-1:ACC_W] == '0) && (pc_o[ACC_W-1:0] == $past(acc_i))
      && (pc_o[PC_W-1:OFS_W] == $past(page_i)));

  a_r9_irq_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && irq_i) |=> pc_o == PC_W'(IRQ_VEC));

  a_r9_ctx_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && irq_i) |=> (acc_sv_o == $past(acc_i)) && (stat_sv_o == $past(status_i))
      && (page_sv_o == $past(page_i)));

  a_r9_ctx_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && irq_i) |=> $stable(acc_sv_o) && $stable(stat_sv_o) && $stable(page_sv_o));

  a_r10_restore_only_on_reti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (step_i && !irq_i && op_i == 3'd4));
endmodule

bind paged_pc paged_pc_chk #(
  .PAGE_W(PAGE_W), .OFS_W(OFS_W), .ACC_W(ACC_W), .STAT_W(STAT_W), .IRQ_VEC(IRQ_VEC)
) u_chk (.*);

// File: tb/sim_paged_pc.sv
`timescale 1ns/1ps
module sim_paged_pc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [9:0]  target_i = '0;
  logic [7:0]  acc_i = '0;
  logic [7:0]  status_i = '0;
  logic [4:0]  page_i = '0;
  logic        irq_i = 1'b0;
  logic [14:0] pc_o;
  logic [7:0]  acc_sv_o, stat_sv_o;
  logic [4:0]  page_sv_o;
  logic        restore_o;

  always #2.5 clk_i = ~clk_i;

  paged_pc u0 (.*);

  int unsigned n_vec = 0, n_bad = 0;
  bit          done = 0;

  logic [14:0] m_pc;
  logic [14:0] m_stk [32];
  logic [4:0]  m_sp;
  logic [7:0]  m_acc, m_st;
  logic [4:0]  m_pg;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] tbl_sum(input logic [14:0] pc, input logic [7:0] a);
    return pc + {7'd0, a};
  endfunction

  task automatic model_reset();
    m_pc = '0; m_sp = '0; m_acc = '0; m_st = '0; m_pg = '0;
    for (int i = 0; i < 32; i++) m_stk[i] = '0;
  endtask

  // called at a negedge; returns at the following negedge
  task automatic cyc(input logic st, input logic [2:0] op, input logic [9:0] tg,
                     input logic [7:0] a, input logic [7:0] s, input logic [4:0] pg,
                     input logic irq);
    logic [14:0] nx, sum;
    string tag;
    step_i = st; op_i = op; target_i = tg; acc_i = a; status_i = s; page_i = pg; irq_i = irq;
    #1;
    chk("R10 restore_o", {31'd0, restore_o}, {31'd0, (st && !irq && op == 3'd4)});
    sum = tbl_sum(m_pc, a);
    if (!st) begin
      nx = m_pc; tag = "R2 hold";
    end else if (irq) begin
      m_stk[m_sp] = m_pc; m_sp = m_sp + 1'b1;
      m_acc = a; m_st = s; m_pg = pg;
      nx = 15'h0008; tag = "R9 irq";
    end else begin
      case (op)
        3'd0: begin nx = m_pc + 1'b1; tag = "R2 inc"; end
        3'd1: begin nx = {pg, tg}; tag = "R3 jmp"; end
        3'd2: begin
          m_stk[m_sp] = m_pc + 1'b1; m_sp = m_sp + 1'b1;
          nx = {pg, tg}; tag = "R4 call";
        end
        3'd3, 3'd4: begin
          m_sp = m_sp - 1'b1; nx = m_stk[m_sp]; tag = "R5 R11 pop";
        end
        3'd5: begin nx = {pg, 2'b00, a}; tag = "R6 movpc"; end
        3'd6: begin nx = {pg, 2'b00, sum[7:0]}; tag = "R7 addpc"; end
        default: begin nx = sum; tag = "R8 tbl"; end
      endcase
    end
    @(posedge clk_i); #1;
    m_pc = nx;
    chk(tag, {17'd0, pc_o}, {17'd0, m_pc});
    chk("R9 saved ctx", {11'd0, acc_sv_o, stat_sv_o, page_sv_o}, {11'd0, m_acc, m_st, m_pg});
    @(negedge clk_i);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd5150);
    model_reset();
    repeat (3) @(negedge clk_i);
    chk("R1 reset pc", {17'd0, pc_o}, 32'd0);
    chk("R1 reset ctx", {11'd0, acc_sv_o, stat_sv_o, page_sv_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: pop from a freshly reset stack gives 0
    cyc(1, 3'd3, 10'h0, 8'h00, 8'h00, 5'd0, 0);
    chk("R1 empty pop", {17'd0, pc_o}, 32'd0);
    // R2: wrap at top of space
    cyc(1, 3'd1, 10'h3FF, 8'h00, 8'h00, 5'd31, 0);
    cyc(1, 3'd0, 10'h0, 8'h00, 8'h00, 5'd0, 0);
    chk("R2 wrap", {17'd0, pc_o}, 32'd0);
    cyc(0, 3'd1, 10'h155, 8'h00, 8'h00, 5'd3, 0);
    // R7/R8: carry into bit 8
    cyc(1, 3'd1, 10'h0F0, 8'h00, 8'h00, 5'd2, 0);
    cyc(1, 3'd7, 10'h0, 8'h20, 8'h00, 5'd9, 0);
    cyc(1, 3'd1, 10'h0F0, 8'h00, 8'h00, 5'd2, 0);
    cyc(1, 3'd6, 10'h0, 8'h20, 8'h00, 5'd9, 0);
    // R11: 33 calls then 34 returns
    for (int i = 0; i < 33; i++) cyc(1, 3'd2, 10'(i * 7), 8'h00, 8'h00, 5'(i), 0);
    for (int i = 0; i < 34; i++) cyc(1, (i % 2) ? 3'd4 : 3'd3, 10'h0, 8'h00, 8'h00, 5'd0, 0);
    // R9/R10: interrupt over a call, then return from it
    cyc(1, 3'd2, 10'h123, 8'hA5, 8'h3C, 5'd17, 1);
    cyc(1, 3'd4, 10'h0, 8'h11, 8'h22, 5'd4, 0);
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 8) != 0, 3'($urandom), 10'($urandom), 8'($urandom),
          8'($urandom), 5'($urandom), ($urandom % 12) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule